// File: doc/BRIEF.md
# Radix-2² Delay-Feedback FFT Stage

This block is one stage of a streaming pipelined FFT built on the radix-2² single-path delay-feedback scheme, using decimation in frequency. Complex fixed-point samples arrive one per valid cycle in natural order. Each sample passes through two cascaded radix-2 butterflies. Each butterfly keeps its own feedback shift register. The second butterfly folds the trivial rotation by −j (A+jB becomes B−jA) into its input. It does this with a real/imaginary swap and a negation, so it needs no multiplier. A position counter of log2(L) bits sequences both butterflies, where L is the block length this stage handles. The first butterfly switches between filling and combining on the counter's top bit. The second switches on the next bit down.

A full transform is built by chaining stages with shrinking block lengths, with a general twiddle multiplier between them that is not part of this block. The final output comes out in bit-reversed order. When the transform length is a power of two but not a power of four, the last stage is built with `HAS_BF2 = 0` and holds only the first butterfly. A valid-qualified frame-start marks the sample that becomes position 0 of a new stream. A two-state fill sequencer keeps the output invalid until the feedback registers hold real data. Its states are FILL, where samples are absorbed with no output, and RUN, where every valid input yields one valid output. It moves from FILL to RUN when the last sample of the latency window is taken. Any state returns to FILL on a valid frame-start, and reset also places it in FILL.

Top module: `sdf_r22_stage`

## Requirements
- R1: After a frame start, the first 3L/4 valid inputs (L/2 with `HAS_BF2 = 0`) produce no valid output. Every later valid input produces exactly one valid output on the next clock. Output index k belongs to block k/L, position k mod L.
- R2: With Q = L/4, for n < Q: output position n is (x[n]+x[n+2Q]) + (x[n+Q]+x[n+3Q]), and output position n+Q is (x[n]+x[n+2Q]) − (x[n+Q]+x[n+3Q]).
- R3: Output position n+2Q is (x[n]−x[n+2Q]) + r, and output position n+3Q is (x[n]−x[n+2Q]) − r, where r = −j·(x[n+Q]−x[n+3Q]). Rotation by −j maps A+jB to B−jA.
- R4: Each butterfly widens the word by one bit, so the output is IN_W+2 bits wide (IN_W+1 with `HAS_BF2 = 0`). Results are exact for every input value, full-scale positive and negative included, with no saturation and no wrap.
- R5: A cycle with `in_valid` low advances neither the counter nor the feedback registers. `out_valid` is low on the next clock and the output data holds. Results equal those of the same samples sent without gaps.
- R6: `frame_start` together with `in_valid` makes that sample position 0 and restarts the FILL window. This holds even in the middle of a block. `frame_start` without `in_valid` is ignored.
- R7: With `HAS_BF2 = 0` and H = L/2, output position n < H is x[n]+x[n+H] and output position n+H is x[n]−x[n+H].
- R8: With L = 4, the four outputs of each block are the 4-point DFT bins in bit-reversed order: X0, X2, X1, X3.
- R9: During and just after reset, `out_valid` is low, the output data is zero, and the sequencer is in FILL at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the input sample |
| frame_start | input | 1 | With in_valid, marks position 0 of a new stream |
| in_re | input | IN_W | Real part of input sample, two's complement |
| in_im | input | IN_W | Imaginary part of input sample, two's complement |
| out_valid | output | 1 | Qualifies the output sample |
| out_re | output | IN_W+1+HAS_BF2 | Real part of output sample |
| out_im | output | IN_W+1+HAS_BF2 | Imaginary part of output sample |

## Verification
The stage is driven with a periodic impulse, which exposes misrouted delay taps and the quarter ordering. Constant full-scale positive and negative frames check that widening is exact and that the rotation's negation never wraps. Alternating extremes with regular gaps check that stalls neither shift the counter nor disturb the feedback contents. Random frames with random gaps, some cut off mid-block by a new frame start, separate correct restart behaviour from a counter that keeps its old phase. A 4-point build is compared against a directly computed DFT in bit-reversed order. A 2-point single-butterfly build checks the odd-power variant.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } fill_state_e;

    function automatic int stage_latency(input int blk_log, input int has_bf2);
        if (has_bf2 != 0)
            return (3 * (2 ** blk_log)) / 4;
        else
            return (2 ** blk_log) / 2;
    endfunction

endpackage

// File: rtl/sdf_delay_line.sv
module sdf_delay_line #(
    parameter int WIDTH = 26,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] taps [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            taps[0] <= din;
            for (int i = 1; i < DEPTH; i++)
                taps[i] <= taps[i-1];
        end
    end

    assign dout = taps[DEPTH-1];
endmodule

// File: rtl/sdf_bf1.sv
// Radix-2 feedback butterfly. sel=0: store input, emit stored difference.
// sel=1: emit stored+input, store stored-input.
module sdf_bf1 #(
    parameter int IN_W  = 12,
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   en,
    input  logic                   sel,
    input  logic signed [IN_W-1:0] a_re,
    input  logic signed [IN_W-1:0] a_im,
    output logic signed [IN_W:0]   y_re,
    output logic signed [IN_W:0]   y_im
);
    localparam int OW = IN_W + 1;

    logic signed [OW-1:0] x_re, x_im;
    logic signed [OW-1:0] d_re, d_im;
    logic signed [OW-1:0] s_re, s_im;
    logic signed [OW-1:0] f_re, f_im;
    logic signed [OW-1:0] w_re, w_im;
    logic [2*OW-1:0]      fb_in, fb_out;

    assign x_re = {a_re[IN_W-1], a_re};
    assign x_im = {a_im[IN_W-1], a_im};

    sdf_delay_line #(.WIDTH(2*OW), .DEPTH(DEPTH)) fb_i (
        .clk  (clk),
        .en   (en),
        .din  (fb_in),
        .dout (fb_out)
    );

    assign {d_re, d_im} = fb_out;

    always_comb begin
        s_re = d_re + x_re;
        s_im = d_im + x_im;
        f_re = d_re - x_re;
        f_im = d_im - x_im;
        w_re = sel ? f_re : x_re;
        w_im = sel ? f_im : x_im;
        y_re = sel ? s_re : d_re;
        y_im = sel ? s_im : d_im;
    end

    assign fb_in = {w_re, w_im};
endmodule

// File: rtl/sdf_bf2.sv
// Second butterfly: optional -j rotation (swap + negate) ahead of a feedback butterfly.
module sdf_bf2 #(
    parameter int IN_W  = 13,
    parameter int DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   en,
    input  logic                   sel,
    input  logic                   rot,
    input  logic signed [IN_W-1:0] a_re,
    input  logic signed [IN_W-1:0] a_im,
    output logic signed [IN_W:0]   y_re,
    output logic signed [IN_W:0]   y_im
);
    logic signed [IN_W-1:0] r_re, r_im;

    // Rotated samples are first-butterfly differences, which never reach the
    // most negative code, so negation in IN_W bits is exact.
    always_comb begin
        if (rot) begin
            r_re = a_im;
            r_im = -a_re;
        end else begin
            r_re = a_re;
            r_im = a_im;
        end
    end

    sdf_bf1 #(.IN_W(IN_W), .DEPTH(DEPTH)) core_i (
        .clk  (clk),
        .en   (en),
        .sel  (sel),
        .a_re (r_re),
        .a_im (r_im),
        .y_re (y_re),
        .y_im (y_im)
    );
endmodule

// File: rtl/sdf_ctrl.sv
module sdf_ctrl
    import sdf_pkg::*;
#(
    parameter int BLK_LOG = 4,
    parameter int HAS_BF2 = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               frame_start,
    output logic               c1,
    output logic               c2,
    output logic               rot,
    output logic [BLK_LOG-1:0] pos_o,
    output logic               out_en_q
);
    localparam int LAT = stage_latency(BLK_LOG, HAS_BF2);
    localparam int CW  = $clog2(LAT + 1);

    fill_state_e        state_q, state_cur, state_nx;
    logic [BLK_LOG-1:0] pos_q, pos_cur;
    logic [CW-1:0]      fill_q, fill_cur, fill_nx;
    logic               restart;

    assign restart = in_valid & frame_start;

    always_comb begin
        pos_cur   = restart ? '0 : pos_q;
        fill_cur  = restart ? '0 : fill_q;
        state_cur = restart ? ST_FILL : state_q;
    end

    // next-state logic
    always_comb begin
        state_nx = state_cur;
        fill_nx  = fill_cur;
        if (in_valid) begin
            unique case (state_cur)
                ST_FILL: begin
                    if (fill_cur == CW'(LAT - 1))
                        state_nx = ST_RUN;
                    else
                        fill_nx = fill_cur + CW'(1);
                end
                ST_RUN: state_nx = ST_RUN;
                default: state_nx = ST_FILL;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            fill_q  <= '0;
            pos_q   <= '0;
        end else begin
            state_q <= state_nx;
            fill_q  <= fill_nx;
            if (in_valid)
                pos_q <= pos_cur + BLK_LOG'(1);
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst)
            out_en_q <= 1'b0;
        else
            out_en_q <= in_valid && (state_cur == ST_RUN);
    end

    assign c1    = pos_cur[BLK_LOG-1];
    assign pos_o = pos_q;

    generate
        if (HAS_BF2 != 0) begin : g_bf2_ctl
            // Second butterfly sees the stream shifted by L/2, so its top bit is inverted.
            assign c2  = pos_cur[BLK_LOG-2];
            assign rot = ~pos_cur[BLK_LOG-1] & pos_cur[BLK_LOG-2];
        end else begin : g_no_bf2_ctl
            assign c2  = 1'b0;
            assign rot = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/sdf_r22_stage.sv
module sdf_r22_stage #(
    parameter int IN_W    = 12,
    parameter int BLK_LOG = 4,
    parameter int HAS_BF2 = 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic                          frame_start,
    input  logic signed [IN_W-1:0]        in_re,
    input  logic signed [IN_W-1:0]        in_im,
    output logic                          out_valid,
    output logic signed [IN_W+HAS_BF2:0]  out_re,
    output logic signed [IN_W+HAS_BF2:0]  out_im
);
    localparam int D1 = 2 ** (BLK_LOG - 1);
    localparam int OW = IN_W + 1 + HAS_BF2;

    logic                   c1, c2, rot;
    logic [BLK_LOG-1:0]     pos;
    logic signed [IN_W:0]   y1_re, y1_im;
    logic signed [OW-1:0]   st_re, st_im;

    sdf_ctrl #(.BLK_LOG(BLK_LOG), .HAS_BF2(HAS_BF2)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .frame_start (frame_start),
        .c1          (c1),
        .c2          (c2),
        .rot         (rot),
        .pos_o       (pos),
        .out_en_q    (out_valid)
    );

    sdf_bf1 #(.IN_W(IN_W), .DEPTH(D1)) bf1_i (
        .clk  (clk),
        .en   (in_valid),
        .sel  (c1),
        .a_re (in_re),
        .a_im (in_im),
        .y_re (y1_re),
        .y_im (y1_im)
    );

    generate
        if (HAS_BF2 != 0) begin : g_bf2
            localparam int D2 = 2 ** (BLK_LOG - 2);
            sdf_bf2 #(.IN_W(IN_W + 1), .DEPTH(D2)) bf2_i (
                .clk  (clk),
                .en   (in_valid),
                .sel  (c2),
                .rot  (rot),
                .a_re (y1_re),
                .a_im (y1_im),
                .y_re (st_re),
                .y_im (st_im)
            );
        end else begin : g_bf1_only
            assign st_re = y1_re;
            assign st_im = y1_im;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_re <= '0;
            out_im <= '0;
        end else if (in_valid) begin
            out_re <= st_re;
            out_im <= st_im;
        end
    end
endmodule

// File: rtl/sdf_r22_stage_chk.sv
module sdf_r22_stage_chk #(
    parameter int OW      = 14,
    parameter int BLK_LOG = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               frame_start,
    input logic               out_valid,
    input logic [OW-1:0]      out_re,
    input logic [OW-1:0]      out_im,
    input logic [BLK_LOG-1:0] pos
);
    assert_idle_no_valid_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_idle_hold_data_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_re) && $stable(out_im)));

    assert_idle_hold_pos_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(pos));

    assert_restart_blank_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && frame_start) |=> !out_valid);

    assert_restart_pos_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && frame_start) |=> (pos == BLK_LOG'(1)));

    assert_advance_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !frame_start) |=> (pos == BLK_LOG'($past(pos) + 1'b1)));

    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && pos == '0 && out_re == '0 && out_im == '0));
endmodule

bind sdf_r22_stage sdf_r22_stage_chk #(.OW(IN_W + 1 + HAS_BF2), .BLK_LOG(BLK_LOG)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .frame_start (frame_start),
    .out_valid   (out_valid),
    .out_re      (out_re),
    .out_im      (out_im),
    .pos         (pos)
);

// File: tb/sdf_r22_stage_tb_top.sv
module sdf_r22_stage_tb_top;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic frame_start = 1'b0;
    logic signed [W-1:0] in_re = '0, in_im = '0;

    logic                 v0, v1, v2;
    logic signed [W+1:0]  r0, i0, r1, i1;
    logic signed [W:0]    r2, i2;

    always #4 clk = ~clk;

    sdf_r22_stage #(.IN_W(W), .BLK_LOG(4), .HAS_BF2(1)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .frame_start(frame_start),
        .in_re(in_re), .in_im(in_im), .out_valid(v0), .out_re(r0), .out_im(i0));

    sdf_r22_stage #(.IN_W(W), .BLK_LOG(2), .HAS_BF2(1)) dut4_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .frame_start(frame_start),
        .in_re(in_re), .in_im(in_im), .out_valid(v1), .out_re(r1), .out_im(i1));

    sdf_r22_stage #(.IN_W(W), .BLK_LOG(1), .HAS_BF2(0)) dut2_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .frame_start(frame_start),
        .in_re(in_re), .in_im(in_im), .out_valid(v2), .out_re(r2), .out_im(i2));

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int xr [0:4095];
    int xi [0:4095];
    int nin = 0;
    int nout [3] = '{0, 0, 0};
    int lat [3] = '{12, 3, 1};
    int phase = 0;
    bit prev_v = 0;

    task automatic check(input string tag, input int ar, input int ai, input int er, input int ei);
        checks++;
        if (ar != er || ai != ei) begin
            errors++;
            $display("FAIL %s: got (%0d,%0d) expected (%0d,%0d)", tag, ar, ai, er, ei);
        end
    endtask

    // multiply (a,b) by (-j)^e
    task automatic rot_mj(input int a, input int b, input int e, output int oa, output int ob);
        case (e & 3)
            0: begin oa = a;  ob = b;  end
            1: begin oa = b;  ob = -a; end
            2: begin oa = -a; ob = -b; end
            default: begin oa = -b; ob = a; end
        endcase
    endtask

    task automatic expected(input int d, input int k, output int er, output int ei, output string tag);
        if (d == 0) begin
            int base = (k >> 4) << 4;
            int r = k & 15;
            int n = r & 3;
            int qd = r >> 2;
            int ar = xr[base+n] + xr[base+n+8],   ai = xi[base+n] + xi[base+n+8];
            int br = xr[base+n+4] + xr[base+n+12], bi = xi[base+n+4] + xi[base+n+12];
            int cr = xr[base+n] - xr[base+n+8],   ci = xi[base+n] - xi[base+n+8];
            int dr = xr[base+n+4] - xr[base+n+12], di = xi[base+n+4] - xi[base+n+12];
            int tr = di, ti = -dr;
            case (qd)
                0: begin er = ar + br; ei = ai + bi; end
                1: begin er = ar - br; ei = ai - bi; end
                2: begin er = cr + tr; ei = ci + ti; end
                default: begin er = cr - tr; ei = ci - ti; end
            endcase
            tag = (qd < 2) ? "R2" : "R3";
            if (phase == 1 || phase == 2) tag = "R4";
        end else if (d == 1) begin
            int base = (k >> 2) << 2;
            int r = k & 3;
            int kk = ((r & 1) << 1) | (r >> 1);
            er = 0; ei = 0;
            for (int n = 0; n < 4; n++) begin
                int pr, pi;
                rot_mj(xr[base+n], xi[base+n], n * kk, pr, pi);
                er += pr; ei += pi;
            end
            tag = "R8";
        end else begin
            int base = (k >> 1) << 1;
            if ((k & 1) == 0) begin
                er = xr[base] + xr[base+1]; ei = xi[base] + xi[base+1];
            end else begin
                er = xr[base] - xr[base+1]; ei = xi[base] - xi[base+1];
            end
            tag = "R7";
        end
    endtask

    task automatic check_outputs();
        bit vv [3];
        int ar [3];
        int ai [3];
        vv[0] = v0; ar[0] = int'(r0); ai[0] = int'(i0);
        vv[1] = v1; ar[1] = int'(r1); ai[1] = int'(i1);
        vv[2] = v2; ar[2] = int'(r2); ai[2] = int'(i2);
        for (int d = 0; d < 3; d++) begin
            if (!prev_v)
                check("R5 out_valid after idle", int'(vv[d]), 0, 0, 0);
            if (vv[d]) begin
                int er, ei;
                string tag;
                expected(d, nout[d], er, ei, tag);
                check(tag, ar[d], ai[d], er, ei);
                nout[d]++;
            end
        end
    endtask

    task automatic count_check();
        for (int d = 0; d < 3; d++) begin
            int e = (nin > lat[d]) ? nin - lat[d] : 0;
            check("R1/R6 output count", nout[d], 0, e, 0);
        end
    endtask

    task automatic step(input bit v, input bit fs, input int re, input int im);
        @(negedge clk);
        check_outputs();
        if (v && fs) begin
            count_check();
            nin = 0;
            nout = '{0, 0, 0};
        end
        if (v) begin
            xr[nin] = re; xi[nin] = im; nin++;
        end
        in_valid = v; frame_start = fs;
        in_re = W'(re); in_im = W'(im);
        prev_v = v;
    endtask

    function automatic int rnd_s();
        return int'($urandom_range(4095)) - 2048;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset valid", int'(v0) + int'(v1) + int'(v2), 0, 0, 0);
        check("R9 reset data", int'(r0), int'(i0), 0, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 after reset", int'(v0), int'(r1), 0, 0);
        // frame_start without valid is ignored (R6)
        step(0, 1, 0, 0);
        for (int p = 0; p < 10; p++) begin
            int len = (p < 3) ? 64 : ((p == 3) ? 70 : 90 + 17 * p);
            phase = p;
            for (int s = 0; s < len; s++) begin
                int re, im;
                bit v = 1;
                case (p)
                    0: begin re = (s % 16 == 0) ? 1000 : 0; im = (s % 16 == 5) ? -500 : 0; end
                    1: begin re = 2047; im = 2047; end
                    2: begin re = -2048; im = -2048; end
                    3: begin re = s[0] ? 2047 : -2048; im = s[1] ? -2048 : 2047; end
                    default: begin re = rnd_s(); im = rnd_s(); end
                endcase
                if (s > 0 && p >= 3) begin
                    while ($urandom_range(3) == 0 || (p == 3 && s % 3 == 0 && v)) begin
                        step(0, 0, 0, 0);
                        v = 0;
                    end
                end
                step(1, s == 0, re, im);
            end
        end
        repeat (4) step(0, 0, 0, 0);
        count_check();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule